// File: doc/BRIEF.md
# Windowed Accumulator Readout with Equalization

This block sweeps a 512-entry, 24-bit histogram accumulator memory from the lowest address to the highest, one word per clock. From each count it makes a 9-bit result: a window of the 24-bit value that starts at a programmable bit position. As an option the result can be forced to all ones when the count has bits set above the window. When equalization is on, the block keeps a running cumulative sum of the counts as it reads them. It then takes the window from that sum instead of from the raw bin, which gives the cumulative distribution needed for histogram equalization.

A readout begins on a high-to-low transition of an active-low start strobe. At that edge the block captures the window position, the saturation, equalization and destination controls, and it clears the running sum. Each result goes to one of two places. It can appear on the output bus, qualified by a valid flag. It can also go to a write port for a transform table, where the table address equals the accumulator address, so an equalization table can be built straight from the histogram. The accumulator memory sits outside the block and is read through a synchronous port with one cycle of read latency.

Top module: `acc_window_readout`

## Requirements
- R1: After reset the block is idle: `acc_rd`, `dout_valid`, `tbl_we` and `busy` are 0 and `dout` is 0. Nothing is read until `start_n` is sampled 1 on one clock edge and 0 on the next edge. That second edge is the trigger edge.
- R2: A readout issues reads for addresses 0 to 511 in ascending order, one per clock, starting at the trigger edge. The result for address k appears after the (k+2)-th rising edge following the trigger edge. After address 511 the block returns to idle.
- R3: With saturation off, the 9-bit result is bits sel+8 down to sel of the selected 24-bit value, where `sel` is the 4-bit window start.
- R4: With saturation on (`sat_en`=1), the result is 511 whenever any bit from sel+9 to 23 of the selected value is 1.
- R5: With saturation off, the window passes through unchanged even when bits above it are set.
- R6: With `eq_en`=1, the selected value is the cumulative sum of the counts at addresses 0 through k, inclusive. The sum is cleared at every trigger edge.
- R7: The cumulative sum is 24 bits wide and saturates at 16777215 instead of wrapping.
- R8: `dout_valid` is 1 exactly while `dout` carries a result. At other times `dout` is 0.
- R9: With `to_table`=1, each result is written through `tbl_we`/`tbl_wdata`, and `tbl_addr` equals the accumulator address. `dout_valid` stays 0.
- R10: A falling `start_n` during an active readout is ignored. The readout neither restarts nor stops.
- R11: `sel`, `sat_en`, `eq_en` and `to_table` are captured at the trigger edge. Changing them during a readout has no effect on that readout.
- R12: A window start of 15 selects bits 23 to 15, so saturation can never force the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_n | input | 1 | Start strobe; a high-to-low transition begins a readout |
| sel | input | 4 | Bit position of the window's least significant bit |
| sat_en | input | 1 | Force the result to 511 when bits above the window are set |
| eq_en | input | 1 | Take the window from the running cumulative sum |
| to_table | input | 1 | Send results to the table write port instead of the output bus |
| acc_rd | output | 1 | Accumulator read enable |
| acc_addr | output | 9 | Accumulator read address |
| acc_rdata | input | 24 | Accumulator read data, one cycle after `acc_rd` |
| dout | output | 9 | Result bus |
| dout_valid | output | 1 | `dout` carries a result |
| tbl_we | output | 1 | Table write enable |
| tbl_addr | output | 9 | Table write address |
| tbl_wdata | output | 9 | Table write data |
| busy | output | 1 | A readout is in progress |

## Verification
The bench targets overflow at both ends of the window:
- A design that looks for overflow at the wrong bits would saturate counts that fit the window, or pass truncated ones. This is exercised with window starts of 0, 5 and 15, and with data whose top byte is set.
- A design that lets the running sum wrap would produce small equalized values after a large one.
- A design that does not clear the sum at each start would shift the whole curve of a second equalized run upward.

Restart strobes and configuration changes are applied in the middle of a readout:
- A design that restarted on a mid-run start would repeat addresses.
- A design that did not latch its controls would change window or destination halfway through.

Both show up as out-of-order words or wrong results. Every word is also checked for its arrival cycle, so an extra or missing pipeline stage is caught.

// File: rtl/acc_window_readout.sv
module acc_window_readout #(
  parameter int CNT_W  = 24,
  parameter int OUT_W  = 9,
  parameter int ADDR_W = 9,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_n,
  input  logic [SEL_W-1:0]  sel,
  input  logic              sat_en,
  input  logic              eq_en,
  input  logic              to_table,
  output logic              acc_rd,
  output logic [ADDR_W-1:0] acc_addr,
  input  logic [CNT_W-1:0]  acc_rdata,
  output logic [OUT_W-1:0]  dout,
  output logic              dout_valid,
  output logic              tbl_we,
  output logic [ADDR_W-1:0] tbl_addr,
  output logic [OUT_W-1:0]  tbl_wdata,
  output logic              busy
);
  localparam int SEL_MAX = CNT_W - OUT_W;
  localparam logic [ADDR_W-1:0] LAST = '1;

  logic              start_q, busy_q, v1;
  logic [ADDR_W-1:0] addr_q, a1;
  logic [SEL_W-1:0]  sel_l, sel_c;
  logic              sat_l, eq_l, tt_l;
  logic [CNT_W-1:0]  sum_q, sum_nx, value, shifted;
  logic [CNT_W:0]    sum_wide;
  logic [OUT_W-1:0]  result;
  logic              trig;

  assign trig     = start_q & ~start_n & ~busy_q;
  assign sum_wide = {1'b0, sum_q} + {1'b0, acc_rdata};
  assign sum_nx   = sum_wide[CNT_W] ? '1 : sum_wide[CNT_W-1:0];
  assign value    = eq_l ? sum_nx : acc_rdata;

  always_comb begin
    sel_c = sel_l;
    if (int'(sel_l) > SEL_MAX) sel_c = SEL_W'(SEL_MAX);
  end

  assign shifted = value >> sel_c;
  assign result  = (sat_l && (shifted >> OUT_W) != '0) ? '1 : shifted[OUT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b1;
      busy_q  <= 1'b0;
      addr_q  <= '0;
      sel_l   <= '0;
      sat_l   <= 1'b0;
      eq_l    <= 1'b0;
      tt_l    <= 1'b0;
    end else begin
      start_q <= start_n;
      if (trig) begin
        busy_q <= 1'b1;
        addr_q <= '0;
        sel_l  <= sel;
        sat_l  <= sat_en;
        eq_l   <= eq_en;
        tt_l   <= to_table;
      end else if (busy_q) begin
        addr_q <= addr_q + 1'b1;
        if (addr_q == LAST) busy_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1         <= 1'b0;
      a1         <= '0;
      sum_q      <= '0;
      dout       <= '0;
      dout_valid <= 1'b0;
      tbl_we     <= 1'b0;
      tbl_addr   <= '0;
      tbl_wdata  <= '0;
    end else begin
      v1 <= busy_q;
      a1 <= addr_q;
      if (trig) sum_q <= '0;
      else if (v1 && eq_l) sum_q <= sum_nx;
      dout_valid <= v1 & ~tt_l;
      dout       <= (v1 & ~tt_l) ? result : '0;
      tbl_we     <= v1 & tt_l;
      tbl_addr   <= a1;
      tbl_wdata  <= result;
    end
  end

  assign acc_rd   = busy_q;
  assign acc_addr = addr_q;
  assign busy     = busy_q;
endmodule

// File: rtl/acc_window_readout_chk.sv
module acc_window_readout_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_rd,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              dout_valid,
  input logic              tbl_we
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd && $past(acc_rd) |-> acc_addr == $past(acc_addr) + 1'b1);

  p_first_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd && !$past(acc_rd) |-> acc_addr == '0);

  p_end_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd && acc_addr == LAST |=> !acc_rd);

  p_one_dest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(dout_valid && tbl_we));

  p_valid_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid || tbl_we) |-> $past(acc_rd, 2));
endmodule

bind acc_window_readout acc_window_readout_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_addr(acc_addr),
  .dout_valid(dout_valid), .tbl_we(tbl_we)
);

// File: tb/tb_acc_window_readout.sv
module tb_acc_window_readout;
  logic clk = 0, rst_n = 0, start_n = 1;
  logic [3:0] sel = 0;
  logic sat_en = 0, eq_en = 0, to_table = 0;
  logic acc_rd, dout_valid, tbl_we, busy;
  logic [8:0] acc_addr, dout, tbl_addr, tbl_wdata;
  logic [23:0] acc_rdata = 0;

  int checks = 0, failures = 0;
  int cyc = 0, cyc0 = 0, k = 0, pat = 0;
  int e_sel = 0;
  bit e_sat = 0, e_eq = 0, e_tt = 0;
  longint esum = 0;
  string tag = "R3";

  acc_window_readout dut (.*);

  always #2 clk = ~clk;

  function automatic logic [23:0] memval(int p, int a);
    case (p)
      0: return 24'(a * a * 37 + a * 1021);
      1: return 24'(a & 63);
      2: return 24'hF00000 | 24'(a);
      default: return 24'h0;
    endcase
  endfunction

  task automatic chk(string r, bit ok, string msg);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s", r, msg);
    end
  endtask

  always_ff @(posedge clk) if (acc_rd) acc_rdata <= memval(pat, int'(acc_addr));

  always @(negedge clk) begin
    cyc++;
    if (dout_valid || tbl_we) begin
      automatic longint v;
      automatic int exp;
      if (e_eq) begin
        esum = esum + memval(pat, k);
        if (esum > 64'hFFFFFF) esum = 64'hFFFFFF;
        v = esum;
      end else v = memval(pat, k);
      if (e_sat && ((v >> (e_sel + 9)) != 0)) exp = 511;
      else exp = int'((v >> e_sel) & 511);
      chk("R2", cyc == cyc0 + 2 + k,
          $sformatf("word %0d at cycle %0d expected %0d", k, cyc - cyc0, k + 2));
      if (e_tt)
        chk(tag, tbl_we && !dout_valid && tbl_addr == 9'(k) && int'(tbl_wdata) == exp,
            $sformatf("word %0d we=%0b addr=%0d data=%0d expected addr=%0d data=%0d",
                      k, tbl_we, tbl_addr, tbl_wdata, k, exp));
      else
        chk(tag, dout_valid && !tbl_we && int'(dout) == exp,
            $sformatf("word %0d valid=%0b dout=%0d expected %0d", k, dout_valid, dout, exp));
      k++;
    end
  end

  // mode: 0 plain, 1 restart strobe mid-run (R10), 2 controls changed mid-run (R11)
  task automatic run(string t, int p, int s, bit sa, bit eq, bit tt, int mode);
    @(negedge clk); #1;
    tag = t; pat = p; sel = 4'(s); sat_en = sa; eq_en = eq; to_table = tt;
    e_sel = (s > 15) ? 15 : s; e_sat = sa; e_eq = eq; e_tt = tt;
    esum = 0; k = 0;
    start_n = 0;
    @(negedge clk); #1;
    cyc0 = cyc;
    start_n = 1;
    for (int i = 0; i < 530; i++) begin
      @(negedge clk); #1;
      if (mode == 1 && i == 100) start_n = 0;
      if (mode == 1 && i == 103) start_n = 1;
      if (mode == 2 && i == 50) begin
        sel = sel ^ 4'd3; sat_en = !sat_en; eq_en = !eq_en; to_table = !to_table;
      end
    end
    chk("R2", k == 512, $sformatf("%s words=%0d expected 512", t, k));
    chk("R2", !acc_rd && !busy, $sformatf("idle rd=%0b busy=%0b expected 0 0", acc_rd, busy));
    chk("R8", !dout_valid && !tbl_we && dout == 0,
        $sformatf("after run valid=%0b we=%0b dout=%0d expected 0 0 0", dout_valid, tbl_we, dout));
  endtask

  task automatic t_reset();
    chk("R1", !acc_rd && !dout_valid && !tbl_we && !busy && dout == 0,
        $sformatf("reset rd=%0b v=%0b we=%0b busy=%0b dout=%0d expected all 0",
                  acc_rd, dout_valid, tbl_we, busy, dout));
    repeat (5) @(negedge clk);
    chk("R1", !acc_rd && !busy, $sformatf("no start rd=%0b expected 0", acc_rd));
  endtask

  task automatic t_window();    run("R3", 0, 0, 0, 0, 0, 0); run("R3", 0, 7, 0, 0, 0, 0); endtask
  task automatic t_saturate();  run("R4", 0, 5, 1, 0, 0, 0); run("R4", 2, 3, 1, 0, 0, 0); endtask
  task automatic t_nosat();     run("R5", 2, 5, 0, 0, 0, 0); endtask
  task automatic t_equalize();  run("R6", 1, 4, 1, 1, 0, 0); run("R6", 1, 4, 1, 1, 0, 0); endtask
  task automatic t_sum_sat();   run("R7", 2, 15, 1, 1, 0, 0); endtask
  task automatic t_table();     run("R9", 0, 2, 1, 1, 1, 0); endtask
  task automatic t_restart();   run("R10", 0, 1, 0, 0, 0, 1); endtask
  task automatic t_latch();     run("R11", 0, 6, 1, 0, 0, 2); endtask
  task automatic t_top();       run("R12", 0, 15, 1, 0, 0, 0); endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_window();
    t_saturate();
    t_nosat();
    t_equalize();
    t_sum_sat();
    t_table();
    t_restart();
    t_latch();
    t_top();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule